// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block is the configuration slave for a display serializer. A host talks to it over four serial lines: an active-low select, a serial clock, a data input and a data output. The data input and output may be joined at the pad into a single bidirectional line. For that reason the block drives its output, and raises its output-enable, only while it is returning read data. Every frame is sixteen clock periods long. The first byte is a command that carries a read/write flag and a seven-bit register address. The second byte is either write data from the host or read data from the slave, most significant bit first.

The serial lines are brought into the core clock domain through synchronizers and sampled on detected edges. The core clock must therefore run several times faster than the serial clock. The register file holds a key register and a mode register. The key register unlocks all other writes only while it contains 0xFF. The mode register carries the color-depth select, the serializer soft-reset and the two-bit driver-level code. Every field leaves the block as a plain output. A host that never reads still works correctly, because writes need no acknowledgement.

Top module: `spi3w_cfg_slave`

## Requirements
- R1: After reset the key and mode registers are zero: `cfg_enabled`, `cfg_rgb24`, `cfg_ser_reset` and `cfg_drv_level` are all 0, and `spi_sdo_oe` is 0.
- R2: A frame is 16 serial-clock rising edges with select low. Command bit 7 is 0 for a write, and command bits 6:0 are the address. The data byte is taken MSB first and committed on the 16th rising edge.
- R3: The key register is at address 0x0F and accepts every write regardless of its current value. `cfg_enabled` is 1 exactly while the key holds 0xFF.
- R4: A write to any address other than 0x0F has no effect while the key is not 0xFF.
- R5: The mode register is at address 0x01. Bit 0 drives `cfg_rgb24`, bit 1 drives `cfg_ser_reset` and bits 5:4 drive `cfg_drv_level`. Bits 7:6 and 3:2 are not stored and read back as 0.
- R6: A command with bit 7 set is a read. The slave returns the addressed register MSB first, with each bit changing on a serial-clock falling edge. The first bit appears on the falling edge after the 8th rising edge.
- R7: `spi_sdo_oe` is 1 only during the data half of a read frame, and 0 during the command byte, during writes and while select is high.
- R8: Raising select before the 16th rising edge abandons the frame without changing any register.
- R9: Reads return register contents while the key is locked.
- R10: An unmapped address reads as 0x00, and writes to it change nothing.
- R11: Serial-clock edges after the 16th within one selection are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Active-low frame select |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data from the host (or the shared line) |
| spi_sdo | output | 1 | Serial read data |
| spi_sdo_oe | output | 1 | Pad enable for `spi_sdo`; 1 only while returning read data |
| cfg_enabled | output | 1 | Key register holds 0xFF |
| cfg_rgb24 | output | 1 | 1 selects 24-bit color, 0 selects 18-bit |
| cfg_ser_reset | output | 1 | 1 holds the serializer in reset |
| cfg_drv_level | output | 2 | Driver swing code (00 higher swing, 01 lower swing) |

## Verification
Some rules are checked by assertions on every cycle. The mode fields never change unless the key held 0xFF and a write strobe was present. The enable output rises only on a key write. The bit counter never passes sixteen. A commit happens only at the sixteenth edge. A high select clears the counter, and the output-enable stays low while select is high. Other behaviours show only in the bench's scenarios: the value returned bit by bit on the shared line, an aborted frame leaving the registers unchanged, surplus clock edges being ignored, and reads working while the key is locked.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned BYTE_BITS  = 8;
  localparam int unsigned ADDR_BITS  = 7;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  localparam logic [ADDR_BITS-1:0] ADDR_MODE = 7'h01;
  localparam logic [ADDR_BITS-1:0] ADDR_KEY  = 7'h0F;
  localparam logic [BYTE_BITS-1:0] KEY_OPEN  = 8'hFF;

  typedef struct packed {
    logic       rgb24;
    logic       ser_reset;
    logic [1:0] drv_level;
  } mode_t;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi3w_shifter.sv
module spi3w_shifter
  import spi3w_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csn_s,
  input  logic                 sclk_s,
  input  logic                 sdi_s,
  input  logic [BYTE_BITS-1:0] rd_data_i,
  output logic [ADDR_BITS-1:0] rd_addr_o,
  output logic                 wr_en_o,
  output logic [ADDR_BITS-1:0] wr_addr_o,
  output logic [BYTE_BITS-1:0] wr_data_o,
  output logic                 sdo_o,
  output logic                 sdo_oe_o
);
  localparam logic [CNT_W-1:0] CNT_CMD_LAST  = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_DATA_FST  = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_DATA_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_BITS);

  logic                 sclk_d_q;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [BYTE_BITS-1:0] shreg_q, shreg_n;
  logic [BYTE_BITS-1:0] cmd_q, cmd_n;
  logic [BYTE_BITS-1:0] tx_q, tx_n;
  logic                 sdo_q, sdo_n;
  logic                 oe_q, oe_n;
  logic                 rise, fall;
  logic [BYTE_BITS-1:0] byte_now;
  logic                 wr_en;

  always_comb begin
    rise     = sclk_s & ~sclk_d_q;
    fall     = ~sclk_s & sclk_d_q;
    byte_now = {shreg_q[BYTE_BITS-2:0], sdi_s};
    cnt_n    = cnt_q;
    shreg_n  = shreg_q;
    cmd_n    = cmd_q;
    tx_n     = tx_q;
    sdo_n    = sdo_q;
    oe_n     = oe_q;
    wr_en    = 1'b0;
    if (csn_s) begin
      cnt_n = '0;
      oe_n  = 1'b0;
    end else begin
      if (rise && (cnt_q < CNT_FULL)) begin
        shreg_n = byte_now;
        cnt_n   = cnt_q + 1'b1;
        if (cnt_q == CNT_CMD_LAST) begin
          cmd_n = byte_now;
          tx_n  = rd_data_i;
        end
        if ((cnt_q == CNT_DATA_LAST) && !cmd_q[BYTE_BITS-1]) begin
          wr_en = 1'b1;
        end
      end
      if (fall) begin
        if (cmd_q[BYTE_BITS-1] && (cnt_q >= CNT_DATA_FST) && (cnt_q <= CNT_DATA_LAST)) begin
          sdo_n = tx_q[BYTE_BITS-1];
          tx_n  = {tx_q[BYTE_BITS-2:0], 1'b0};
          oe_n  = 1'b1;
        end else begin
          oe_n  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      cmd_q    <= '0;
      tx_q     <= '0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cnt_q    <= cnt_n;
      shreg_q  <= shreg_n;
      cmd_q    <= cmd_n;
      tx_q     <= tx_n;
      sdo_q    <= sdo_n;
      oe_q     <= oe_n;
    end
  end

  assign rd_addr_o = byte_now[ADDR_BITS-1:0];
  assign wr_en_o   = wr_en;
  assign wr_addr_o = cmd_q[ADDR_BITS-1:0];
  assign wr_data_o = byte_now;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL); // R11
  AST_COMMIT_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == CNT_FULL)); // R2
  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (cnt_q == '0)); // R8
  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && $past(csn_s)) |-> !oe_q); // R7
endmodule

// File: rtl/spi3w_regfile.sv
module spi3w_regfile
  import spi3w_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [ADDR_BITS-1:0] wr_addr_i,
  input  logic [BYTE_BITS-1:0] wr_data_i,
  input  logic [ADDR_BITS-1:0] rd_addr_i,
  output logic [BYTE_BITS-1:0] rd_data_o,
  output logic                 enabled_o,
  output mode_t                mode_o
);
  logic [BYTE_BITS-1:0] key_q, key_n;
  mode_t                mode_q, mode_n;
  logic                 unlocked;

  always_comb begin
    unlocked = (key_q == KEY_OPEN);
    key_n    = key_q;
    mode_n   = mode_q;
    if (wr_en_i) begin
      if (wr_addr_i == ADDR_KEY) begin
        key_n = wr_data_i;
      end else if (unlocked && (wr_addr_i == ADDR_MODE)) begin
        mode_n.rgb24     = wr_data_i[0];
        mode_n.ser_reset = wr_data_i[1];
        mode_n.drv_level = wr_data_i[5:4];
      end
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      ADDR_KEY:  rd_data_o = key_q;
      ADDR_MODE: rd_data_o = {2'b00, mode_q.drv_level, 2'b00, mode_q.ser_reset, mode_q.rgb24};
      default:   rd_data_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      mode_q <= '0;
    end else begin
      key_q  <= key_n;
      mode_q <= mode_n;
    end
  end

  assign enabled_o = unlocked;
  assign mode_o    = mode_q;

  AST_MODE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> ($past(key_q) == KEY_OPEN) && $past(wr_en_i)); // R4
  AST_ENABLE_BY_KEY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enabled_o) |-> $past(wr_en_i) && ($past(wr_addr_i) == ADDR_KEY)); // R3
endmodule

// File: rtl/spi3w_cfg_slave.sv
module spi3w_cfg_slave
  import spi3w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_csn,
  input  logic       spi_sclk,
  input  logic       spi_sdi,
  output logic       spi_sdo,
  output logic       spi_sdo_oe,
  output logic       cfg_enabled,
  output logic       cfg_rgb24,
  output logic       cfg_ser_reset,
  output logic [1:0] cfg_drv_level
);
  logic [2:0]           pins_s;
  logic                 csn_s, sclk_s, sdi_s;
  logic [ADDR_BITS-1:0] rd_addr, wr_addr;
  logic [BYTE_BITS-1:0] rd_data, wr_data;
  logic                 wr_en;
  mode_t                mode;

  spi3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({spi_csn, spi_sclk, spi_sdi}),
    .q_o   (pins_s)
  );
  assign {csn_s, sclk_s, sdi_s} = pins_s;

  spi3w_shifter shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn_s     (csn_s),
    .sclk_s    (sclk_s),
    .sdi_s     (sdi_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sdo_o     (spi_sdo),
    .sdo_oe_o  (spi_sdo_oe)
  );

  spi3w_regfile regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .enabled_o (cfg_enabled),
    .mode_o    (mode)
  );

  assign cfg_rgb24     = mode.rgb24;
  assign cfg_ser_reset = mode.ser_reset;
  assign cfg_drv_level = mode.drv_level;
endmodule

// File: tb/spi3w_cfg_slave_tb.sv
module spi3w_cfg_slave_tb_top;
  localparam int HALF = 8;

  logic clk, rst_n, csn, sclk, host_bit;
  logic sdo, sdo_oe, enabled, rgb24, ser_rst;
  logic [1:0] drv;
  logic line;
  int n_checks, n_fail;
  logic [7:0] rd;
  int oe_bad;

  assign line = sdo_oe ? sdo : host_bit;

  spi3w_cfg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk), .spi_sdi(line),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .cfg_enabled(enabled),
    .cfg_rgb24(rgb24), .cfg_ser_reset(ser_rst), .cfg_drv_level(drv)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // nbits rising edges; bits past 16 send 1. Records oe misuse in oe_bad.
  task automatic xfer(input logic rw, input logic [6:0] addr, input logic [7:0] wdat,
                      input int nbits, output logic [7:0] rdat);
    logic [15:0] frame;
    frame = {rw, addr, wdat};
    rdat = '0;
    oe_bad = 0;
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      host_bit = (i < 16) ? frame[15-i] : 1'b1;
      wait_clk(HALF);
      if (i >= 8 && i < 16) begin
        if (rw) begin
          rdat[15-i] = line;
          if (!sdo_oe) oe_bad++;
        end else if (sdo_oe) oe_bad++;
      end else if (sdo_oe) oe_bad++;
      sclk = 1'b1;
      wait_clk(HALF);
    end
    sclk = 1'b0;
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(HALF);
    if (sdo_oe) oe_bad++;
  endtask

  task automatic t_reset;
    check("R1 enabled", enabled, 0);
    check("R1 rgb24", rgb24, 0);
    check("R1 ser_reset", ser_rst, 0);
    check("R1 drv_level", drv, 0);
    check("R1 oe", sdo_oe, 0);
  endtask

  task automatic t_locked_write;
    xfer(1'b0, 7'h01, 8'h33, 16, rd);
    check("R4 locked mode write rgb24", rgb24, 0);
    check("R4 locked mode write drv", drv, 0);
    check("R7 oe low during write", oe_bad, 0);
    xfer(1'b1, 7'h01, 8'h00, 16, rd);
    check("R9 read while locked", rd, 8'h00);
    check("R7 oe only in read data phase", oe_bad, 0);
  endtask

  task automatic t_unlock;
    xfer(1'b0, 7'h0F, 8'hFF, 16, rd);
    check("R3 enabled after key FF", enabled, 1);
    xfer(1'b1, 7'h0F, 8'h00, 16, rd);
    check("R6 key readback", rd, 8'hFF);
  endtask

  task automatic t_mode;
    xfer(1'b0, 7'h01, 8'h31, 16, rd);
    check("R5 rgb24", rgb24, 1);
    check("R5 ser_reset", ser_rst, 0);
    check("R5 drv_level", drv, 2'b11);
    check("R2 write frame", {rgb24, ser_rst, drv}, 4'b1011);
    xfer(1'b1, 7'h01, 8'h00, 16, rd);
    check("R6 mode readback", rd, 8'h31);
    xfer(1'b0, 7'h01, 8'hFE, 16, rd);
    check("R5 ser_reset set", ser_rst, 1);
    check("R5 rgb24 clear", rgb24, 0);
    xfer(1'b1, 7'h01, 8'h00, 16, rd);
    check("R5 reserved bits read 0", rd, 8'h32);
  endtask

  task automatic t_abort;
    xfer(1'b0, 7'h01, 8'h10, 12, rd);
    xfer(1'b1, 7'h01, 8'h00, 16, rd);
    check("R8 aborted mode write", rd, 8'h32);
    xfer(1'b0, 7'h0F, 8'h00, 15, rd);
    check("R8 aborted key write", enabled, 1);
  endtask

  task automatic t_extra_clocks;
    xfer(1'b0, 7'h01, 8'h01, 19, rd);
    check("R11 extra edges ignored", {rgb24, ser_rst, drv}, 4'b1000);
  endtask

  task automatic t_unmapped;
    xfer(1'b0, 7'h20, 8'h55, 16, rd);
    xfer(1'b1, 7'h20, 8'h00, 16, rd);
    check("R10 unmapped reads 0", rd, 8'h00);
    check("R10 no side effect", {enabled, rgb24, ser_rst, drv}, 5'b11000);
  endtask

  task automatic t_relock;
    xfer(1'b0, 7'h0F, 8'hFE, 16, rd);
    check("R3 key FE disables", enabled, 0);
    xfer(1'b0, 7'h01, 8'h12, 16, rd);
    check("R4 write ignored after relock", {rgb24, ser_rst, drv}, 4'b1000);
    xfer(1'b1, 7'h0F, 8'h00, 16, rd);
    check("R9 key read while locked", rd, 8'hFE);
    xfer(1'b1, 7'h01, 8'h00, 16, rd);
    check("R9 mode read while locked", rd, 8'h01);
    check("R7 oe discipline", oe_bad, 0);
  endtask

  initial begin
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; csn = 1'b1; sclk = 1'b0; host_bit = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_locked_write();
    t_unlock();
    t_mode();
    t_abort();
    t_extra_clocks();
    t_unmapped();
    t_relock();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule